// File: doc/BRIEF.md
# Serial Flash Page-Program Controller

This block is the device-side command logic for writing a serial flash over SPI mode 0. It samples the serial clock, chip select and data line in the system clock domain, decodes two commands (write enable and page program), and collects the data of a page program into a page buffer in which each byte carries a valid bit. The buffer holds one full page of 256 bytes, and the column wraps inside the page.

When chip select rises, the block checks the frame. If the frame is valid and write is enabled, a self-timed programming cycle starts. This cycle walks the page, ANDs each buffered byte into the storage array, and holds a busy flag for a fixed number of clocks. The write-enable flag clears when the cycle ends. A synchronous read port on the array lets the surrounding logic observe the stored contents.

Top module: `spp_page_prog`

## Requirements
- R1: A frame of exactly one byte, 06h, that ends on a byte boundary sets the write-enable flag `wel`. The flag is 0 after reset.
- R2: A page-program frame received while `wel` is 0 starts no cycle and leaves the array unchanged.
- R3: Bits are sampled MSB first on rising SCK. A page-program frame is 02h, then three address bytes (high, middle, low), then data bytes. Address bits [ADDR_W-1:8] select the page and the low byte selects the starting column.
- R4: Programming stores the AND of the old array byte and the buffered byte, so a bit can only change from 1 to 0.
- R5: The column increments after each data byte and wraps from FFh to 00h within the same page, so that when more than 256 bytes are sent, the last 256 are the ones programmed.
- R6: Bytes of the page that received no data in the frame keep their old values.
- R7: A page program whose chip select rises when the bit count is not a multiple of 8 is discarded, and `wel` stays set.
- R8: A page program that ends after the address with no data byte is discarded, and `wel` stays set.
- R9: An accepted page program raises `busy` within a few clocks of chip select rising. `busy` then stays high for exactly max(TPP_CYCLES, 512) clocks.
- R10: `wel` is cleared on the clock edge at which `busy` falls.
- R11: Frames that begin while `busy` is high have no effect: they do not set `wel` and they do not touch the buffer or the array.
- R12: A frame with any other opcode changes neither `wel` nor `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI serial clock, mode 0, asynchronous to clk |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data into the device |
| busy | output | 1 | Programming cycle in progress |
| wel | output | 1 | Write-enable flag |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array byte at rd_addr, one clock later |

## Verification
The embedded assertions check the following relations on every clock:
- no cycle starts without `wel` or while `busy` is high;
- the buffer is never written during `busy`;
- the page walk has finished before `busy` drops;
- `wel` is already low when `busy` falls;
- chip-select start and end pulses never coincide;
- a completed byte is only reported inside a frame.

Only the scenarios can show the data effects. These are the AND merge, the wrap that keeps the last 256 bytes, the untouched bytes, the exact busy length, and the rejection of misaligned, data-less, unenabled or overlapping frames. The scenarios show them by reading whole pages back and comparing them with a model in the bench.

// File: rtl/spp_pkg.sv
package spp_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam int PAGE_W = 8;

  typedef enum logic [2:0] {
    IDX_OP,
    IDX_A2,
    IDX_A1,
    IDX_A0,
    IDX_DATA
  } byte_idx_e;
endpackage

// File: rtl/spp_spi_rx.sv
module spp_spi_rx (
  input  logic       clk,
  input  logic       rst,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       byte_vld,
  output logic [7:0] byte_dat,
  output logic       frm_start,
  output logic       frm_end,
  output logic       on_boundary
);
  logic [2:0] sck_s;
  logic [2:0] cs_s;
  logic [1:0] di_s;
  logic [2:0] bit_cnt;
  logic [6:0] shf;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_s       <= '0;
      cs_s        <= '1;
      di_s        <= '0;
      bit_cnt     <= '0;
      shf         <= '0;
      byte_vld    <= 1'b0;
      byte_dat    <= '0;
      frm_start   <= 1'b0;
      frm_end     <= 1'b0;
      on_boundary <= 1'b1;
    end else begin
      sck_s       <= {sck_s[1:0], sclk};
      cs_s        <= {cs_s[1:0], cs_n};
      di_s        <= {di_s[0], mosi};
      byte_vld    <= 1'b0;
      frm_start   <= cs_s[2] & ~cs_s[1];
      frm_end     <= ~cs_s[2] & cs_s[1];
      on_boundary <= (bit_cnt == 3'd0);
      if (cs_s[1]) begin
        bit_cnt <= '0;
      end else if (sck_s[1] & ~sck_s[2]) begin
        shf     <= {shf[5:0], di_s[1]};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_vld <= 1'b1;
          byte_dat <= {shf, di_s[1]};
        end
      end
    end
  end

  // R3: chip-select start and end pulses are never reported together
  a_r3_edges_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(frm_start && frm_end));

  // R3: a completed byte is only reported while chip select is low
  a_r3_byte_in_frame: assert property (@(posedge clk) disable iff (rst)
    byte_vld |-> !cs_s[2]);
endmodule

// File: rtl/spp_cmd_ctrl.sv
module spp_cmd_ctrl
  import spp_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     byte_vld,
  input  logic [7:0]               byte_dat,
  input  logic                     frm_start,
  input  logic                     frm_end,
  input  logic                     on_boundary,
  input  logic                     busy,
  input  logic                     finishing,
  output logic                     wel,
  output logic                     buf_clr,
  output logic                     buf_we,
  output logic [PAGE_W-1:0]        buf_col,
  output logic [7:0]               buf_wd,
  output logic                     prog_start,
  output logic [ADDR_W-PAGE_W-1:0] prog_page
);
  localparam int PG_W = ADDR_W - PAGE_W;

  byte_idx_e         idx;
  logic [7:0]        opcode;
  logic [PAGE_W-1:0] col;
  logic [PG_W-1:0]   page_q;
  logic              got_data;
  logic              ignore;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx        <= IDX_OP;
      opcode     <= '0;
      col        <= '0;
      page_q     <= '0;
      got_data   <= 1'b0;
      ignore     <= 1'b0;
      wel        <= 1'b0;
      buf_clr    <= 1'b0;
      buf_we     <= 1'b0;
      buf_col    <= '0;
      buf_wd     <= '0;
      prog_start <= 1'b0;
      prog_page  <= '0;
    end else begin
      buf_clr    <= 1'b0;
      buf_we     <= 1'b0;
      prog_start <= 1'b0;
      if (finishing) wel <= 1'b0;

      if (frm_start) begin
        idx      <= IDX_OP;
        opcode   <= '0;
        got_data <= 1'b0;
        ignore   <= busy;
        buf_clr  <= !busy;
      end else if (byte_vld && !ignore) begin
        case (idx)
          IDX_OP: begin
            opcode <= byte_dat;
            idx    <= IDX_A2;
          end
          IDX_A2: idx <= IDX_A1;
          IDX_A1: begin
            page_q <= byte_dat[PG_W-1:0];
            idx    <= IDX_A0;
          end
          IDX_A0: begin
            col <= byte_dat;
            idx <= IDX_DATA;
          end
          default: begin
            if (opcode == OP_PROG) begin
              buf_we   <= 1'b1;
              buf_col  <= col;
              buf_wd   <= byte_dat;
              col      <= col + 1'b1;
              got_data <= 1'b1;
            end
          end
        endcase
      end

      if (frm_end && !ignore && on_boundary && !busy) begin
        if (opcode == OP_WREN && idx == IDX_A2) wel <= 1'b1;
        if (opcode == OP_PROG && idx == IDX_DATA && got_data && wel) begin
          prog_start <= 1'b1;
          prog_page  <= page_q;
        end
      end
    end
  end

  // R2: a programming cycle is only launched with write enabled
  a_r2_start_needs_wel: assert property (@(posedge clk) disable iff (rst)
    prog_start |-> wel);

  // R11: no buffer write and no new launch while a cycle runs
  a_r11_quiet_when_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!buf_we && !prog_start));
endmodule

// File: rtl/spp_page_buf.sv
module spp_page_buf #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              we,
  input  logic [PAGE_W-1:0] wcol,
  input  logic [7:0]        wd,
  input  logic [PAGE_W-1:0] rcol,
  output logic [7:0]        rd,
  output logic              rvld
);
  localparam int DEPTH = 1 << PAGE_W;

  logic [7:0]       dmem [DEPTH];
  logic [DEPTH-1:0] vld;

  always_ff @(posedge clk) begin
    if (we) dmem[wcol] <= wd;
    rd <= dmem[rcol];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      vld  <= '0;
      rvld <= 1'b0;
    end else begin
      if (we) vld[wcol] <= 1'b1;
      rvld <= vld[rcol];
    end
  end
endmodule

// File: rtl/spp_array.sv
module spp_array #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_we,
  input  logic [7:0]        a_wd,
  output logic [7:0]        a_rd,
  input  logic [ADDR_W-1:0] b_addr,
  output logic [7:0]        b_rd
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wd;
    a_rd <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rd <= mem[b_addr];
  end
endmodule

// File: rtl/spp_prog_engine.sv
module spp_prog_engine #(
  parameter int ADDR_W     = 10,
  parameter int PAGE_W     = 8,
  parameter int TPP_CYCLES = 600
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [ADDR_W-PAGE_W-1:0] page,
  output logic                     busy,
  output logic                     finishing,
  output logic [PAGE_W-1:0]        buf_rcol,
  input  logic [7:0]               buf_rd,
  input  logic                     buf_rvld,
  output logic [ADDR_W-1:0]        arr_addr,
  output logic                     arr_we,
  output logic [7:0]               arr_wd,
  input  logic [7:0]               arr_rd
);
  localparam int PG_W   = ADDR_W - PAGE_W;
  localparam int WALK   = 2 << PAGE_W;
  localparam int HOLD   = (TPP_CYCLES > WALK) ? TPP_CYCLES : WALK;
  localparam int CNT_W  = $clog2(HOLD + 1);
  localparam int STEP_W = PAGE_W + 2;

  logic [CNT_W-1:0]  cnt;
  logic [STEP_W-1:0] step;
  logic [PG_W-1:0]   page_q;
  logic              walking;
  logic [PAGE_W-1:0] col;

  assign walking   = busy && (step < STEP_W'(WALK));
  assign col       = step[PAGE_W:1];
  assign finishing = busy && (cnt == '0);
  assign buf_rcol  = col;
  assign arr_addr  = {page_q, col};
  assign arr_we    = walking && step[0] && buf_rvld;
  assign arr_wd    = arr_rd & buf_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      step   <= '0;
      page_q <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      cnt    <= CNT_W'(HOLD - 1);
      step   <= '0;
      page_q <= page;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
      if (walking) step <= step + 1'b1;
    end
  end

  // R9: the page walk is complete before busy is released
  a_r9_walk_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (step == STEP_W'(WALK)));
endmodule

// File: rtl/spp_page_prog.sv
module spp_page_prog
  import spp_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int TPP_CYCLES = 600
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              busy,
  output logic              wel,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int PG_W = ADDR_W - PAGE_W;

  logic              byte_vld, frm_start, frm_end, on_boundary;
  logic [7:0]        byte_dat;
  logic              buf_clr, buf_we, prog_start, finishing;
  logic [PAGE_W-1:0] buf_col, buf_rcol;
  logic [7:0]        buf_wd, buf_rd, arr_wd, arr_rd;
  logic              buf_rvld, arr_we;
  logic [PG_W-1:0]   prog_page;
  logic [ADDR_W-1:0] arr_addr;

  spp_spi_rx u_rx (
    .clk(clk), .rst(rst), .sclk(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .byte_vld(byte_vld), .byte_dat(byte_dat), .frm_start(frm_start),
    .frm_end(frm_end), .on_boundary(on_boundary)
  );

  spp_cmd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_dat(byte_dat),
    .frm_start(frm_start), .frm_end(frm_end), .on_boundary(on_boundary),
    .busy(busy), .finishing(finishing), .wel(wel), .buf_clr(buf_clr),
    .buf_we(buf_we), .buf_col(buf_col), .buf_wd(buf_wd),
    .prog_start(prog_start), .prog_page(prog_page)
  );

  spp_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk(clk), .rst(rst), .clr(buf_clr), .we(buf_we), .wcol(buf_col),
    .wd(buf_wd), .rcol(buf_rcol), .rd(buf_rd), .rvld(buf_rvld)
  );

  spp_prog_engine #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .TPP_CYCLES(TPP_CYCLES)) u_eng (
    .clk(clk), .rst(rst), .start(prog_start), .page(prog_page), .busy(busy),
    .finishing(finishing), .buf_rcol(buf_rcol), .buf_rd(buf_rd),
    .buf_rvld(buf_rvld), .arr_addr(arr_addr), .arr_we(arr_we),
    .arr_wd(arr_wd), .arr_rd(arr_rd)
  );

  spp_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .a_addr(arr_addr), .a_we(arr_we), .a_wd(arr_wd),
    .a_rd(arr_rd), .b_addr(rd_addr), .b_rd(rd_data)
  );

  // R10: write enable is already low when busy drops
  a_r10_wel_off_at_end: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !wel);

  // R9: a launch never arrives while a cycle is running
  a_r9_start_when_idle: assert property (@(posedge clk) disable iff (rst)
    prog_start |-> !busy);
endmodule

// File: tb/tb_spp_page_prog.sv
`timescale 1ns/1ps
module tb_spp_page_prog;
  localparam int ADDR_W = 10;
  localparam int TPP    = 600;
  localparam int HOLD   = (TPP > 512) ? TPP : 512;
  localparam int HALF   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic busy, wel;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [7:0] rd_data;

  always #2 clk = ~clk;

  spp_page_prog #(.ADDR_W(ADDR_W), .TPP_CYCLES(TPP)) dut (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .busy(busy), .wel(wel), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int n_tests = 0, n_fail = 0;
  int busy_len = 0;
  logic [7:0] model [1 << ADDR_W];
  logic exp_wel = 1'b0;

  logic [ADDR_W-1:0] sb_addr[$];
  logic [7:0]        sb_exp[$];
  string             sb_tag[$];
  logic              mon_busy = 1'b0;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (busy) busy_len++;

  // monitor: pops expected items and compares against the read port
  initial begin
    forever begin
      @(negedge clk);
      if (sb_addr.size() != 0) begin
        logic [ADDR_W-1:0] a;
        logic [7:0] e;
        string t;
        mon_busy = 1'b1;
        a = sb_addr.pop_front();
        e = sb_exp.pop_front();
        t = sb_tag.pop_front();
        rd_addr = a;
        @(negedge clk);
        chk(rd_data === e, t, rd_data, e);
        mon_busy = 1'b0;
      end
    end
  end

  task automatic verify_page(input int p, input string tag);
    for (int c = 0; c < 256; c++) begin
      sb_addr.push_back(ADDR_W'(p * 256 + c));
      sb_exp.push_back(model[p * 256 + c]);
      sb_tag.push_back(tag);
    end
    while (sb_addr.size() != 0 || mon_busy) @(negedge clk);
  endtask

  task automatic send_bit(input logic v);
    mosi = v;
    repeat (HALF) @(negedge clk);
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic spi_xfer(input logic [7:0] bytes[$], input int tail_bits);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    foreach (bytes[i])
      for (int b = 7; b >= 0; b--) send_bit(bytes[i][b]);
    for (int t = 0; t < tail_bits; t++) send_bit(1'b1);
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic do_wren();
    logic [7:0] f[$];
    f.push_back(8'h06);
    spi_xfer(f, 0);
  endtask

  task automatic do_pp(input logic [23:0] addr, input logic [7:0] data[$],
                       input int tail, input logic expect_ok);
    logic [7:0] f[$];
    logic [7:0] tmp [256];
    logic       v [256];
    logic [7:0] col;
    int         pg;
    f.push_back(8'h02);
    f.push_back(addr[23:16]);
    f.push_back(addr[15:8]);
    f.push_back(addr[7:0]);
    foreach (data[i]) f.push_back(data[i]);
    busy_len = 0;
    spi_xfer(f, tail);
    if (expect_ok) begin
      for (int c = 0; c < 256; c++) v[c] = 1'b0;
      col = addr[7:0];
      foreach (data[i]) begin
        tmp[col] = data[i];
        v[col] = 1'b1;
        col = col + 8'd1;
      end
      pg = int'(addr[ADDR_W-1:8]);
      for (int c = 0; c < 256; c++)
        if (v[c]) model[pg * 256 + c] = model[pg * 256 + c] & tmp[c];
    end
  endtask

  task automatic wait_idle();
    repeat (10) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d[$];
    for (int i = 0; i < (1 << ADDR_W); i++) model[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // reset state
    chk(wel == 1'b0, "R1 reset wel", wel, 0);
    chk(busy == 1'b0, "R9 reset busy", busy, 0);

    // R2: page program without write enable
    d = '{8'h00, 8'h11};
    do_pp(24'h000020, d, 0, 1'b0);
    chk(busy == 1'b0, "R2 no busy without wel", busy, 0);
    wait_idle();
    verify_page(0, "R2 array untouched");

    // R1: write enable
    do_wren();
    exp_wel = 1'b1;
    chk(wel == 1'b1, "R1 wel set", wel, 1);

    // R12: unknown opcode
    d = '{8'h9F, 8'h00};
    spi_xfer(d, 0);
    chk(wel == 1'b1, "R12 wel kept", wel, 1);
    chk(busy == 1'b0, "R12 no busy", busy, 0);

    // R3/R6/R9/R10: normal program
    d = '{8'h5A, 8'h0F, 8'hF0, 8'h00};
    do_pp(24'h000010, d, 0, 1'b1);
    chk(busy == 1'b1, "R9 busy raised", busy, 1);
    wait_idle();
    chk(busy_len == HOLD, "R9 busy length", busy_len, HOLD);
    chk(wel == 1'b0, "R10 wel cleared", wel, 0);
    verify_page(0, "R3 R6 page0 contents");

    // R4: AND merge
    do_wren();
    d = '{8'hFF, 8'h3C};
    do_pp(24'hFF0010, d, 0, 1'b1);
    wait_idle();
    verify_page(0, "R4 and merge");

    // R5: wrap with 300 bytes into page 1 starting at column 80h
    do_wren();
    d = {};
    for (int k = 0; k < 300; k++) d.push_back(8'((k * 7 + 3) & 8'hFF));
    do_pp(24'h000180, d, 0, 1'b1);
    wait_idle();
    verify_page(1, "R5 wrap keeps last 256");

    // R7: misaligned chip-select rise
    do_wren();
    d = '{8'h00, 8'h00};
    do_pp(24'h000200, d, 3, 1'b0);
    chk(busy == 1'b0, "R7 no busy misaligned", busy, 0);
    chk(wel == 1'b1, "R7 wel kept", wel, 1);

    // R8: no data byte
    d = {};
    do_pp(24'h000200, d, 0, 1'b0);
    chk(busy == 1'b0, "R8 no busy without data", busy, 0);
    chk(wel == 1'b1, "R8 wel kept", wel, 1);
    wait_idle();
    verify_page(2, "R7 R8 page2 untouched");

    // R11: commands during busy
    d = '{8'h12, 8'h34, 8'h56};
    do_pp(24'h0002FE, d, 0, 1'b1);
    chk(busy == 1'b1, "R11 busy before overlap", busy, 1);
    do_wren();
    d = '{8'h00, 8'h00, 8'h00};
    do_pp(24'h000300, d, 0, 1'b0);
    wait_idle();
    chk(wel == 1'b0, "R11 wren ignored while busy", wel, 0);
    verify_page(3, "R11 page3 untouched");
    verify_page(2, "R5 page2 wrap small");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule